// File: doc/BRIEF.md
# Processor Status Word Flag Unit

This block keeps the 8-bit status word of a small accumulator processor. It also contains the 8-bit adder/subtractor whose flags land in that word. Every cycle the core presents two operands, a carry-in and an operation select. The block returns the arithmetic result in the same cycle. When `op_valid` is high, the carry, half-carry and signed-overflow flags are captured at the next clock edge. The parity bit follows the accumulator on every clock, whatever else happens in that cycle.

The same word holds a user flag and a two-bit register-bank select field, which is also driven out on its own port. Software-visible writes come in three forms: a whole-byte store, a single-bit store, and dedicated set/clear strobes for the carry bit. When several updates land in the same cycle, a fixed priority decides which one wins.

Status word layout: bit 7 CY, bit 6 AC, bit 5 F0, bit 4 RS1, bit 3 RS0, bit 2 OV, bit 1 spare, bit 0 P.

Top module: `status_flag_unit`

## Requirements
- R1: `result` is combinational from the inputs in the same cycle. For op_sel 2'b00 (add) and 2'b11 (treated as add) it is a+b. For 2'b01 (add with carry) it is a+b+carry_in. For 2'b10 (subtract with borrow) it is a-b-carry_in. All results are taken modulo 256.
- R2: When op_valid is high, status bit 7 (CY) takes the carry out of bit 7 at the next edge. For subtract it takes the borrow instead, which is 1 when a < b+carry_in as unsigned values.
- R3: When op_valid is high, status bit 6 (AC) takes the carry from bit 3 into bit 4 at the next edge. For subtract it takes the borrow out of the low nibble.
- R4: When op_valid is high, status bit 2 (OV) is set at the next edge when the signed result falls outside -128..127. Otherwise it is cleared.
- R5: Status bit 0 (P) equals, one edge later, the odd parity of acc_in: 1 when acc_in holds an odd number of ones. Byte and bit writes to bit 0 are ignored.
- R6: bank_sel always equals status bits {4,3}. It reads 2'b00, which selects bank 0, after reset.
- R7: cy_set forces CY to 1 and cy_clr forces CY to 0 at the next edge. cy_set wins when both are asserted. An arithmetic update in the same cycle overrides both.
- R8: Status bit 5 (F0) changes only through a byte or bit write. Arithmetic never alters it.
- R9: A byte write loads bits 7..1 from wr_data. A bit write then loads wr_bit_val into bit wr_bit_idx, taking precedence over the byte write. The carry strobes and arithmetic apply after both.
- R10: With rst_n low at a clock edge, the whole status word becomes 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Capture arithmetic flags at this edge |
| op_sel | input | 2 | 00 add, 01 add with carry, 10 subtract with borrow, 11 add |
| opnd_a | input | 8 | First operand |
| opnd_b | input | 8 | Second operand |
| carry_in | input | 1 | Carry/borrow input for op_sel 01 and 10 |
| acc_in | input | 8 | Current accumulator value, source of parity |
| wr_byte_en | input | 1 | Whole status byte write |
| wr_data | input | 8 | Data for the byte write |
| wr_bit_en | input | 1 | Single status bit write |
| wr_bit_idx | input | 3 | Bit position for the bit write |
| wr_bit_val | input | 1 | Value for the bit write |
| cy_set | input | 1 | Force carry to 1 |
| cy_clr | input | 1 | Force carry to 0 |
| result | output | 8 | Arithmetic result |
| status | output | 8 | Status word |
| bank_sel | output | 2 | Register-bank select field |

## Verification
`result` is due in the same cycle the operands are driven. The bench therefore checks it one time unit after driving, while the clock is still low. Every status field, including parity and bank_sel, is due exactly one rising edge after its cause. The bench drives inputs at a falling edge, lets one rising edge pass, and checks each status field at the following falling edge against a reference word that it advances once per edge. Directed cases cover the add and subtract boundaries, the collision priorities and writes aimed at the parity bit. A randomised run then mixes all of these.

// File: rtl/sfu_pkg.sv
// Shared definitions for the status flag unit.
// Assumes an 8-bit status word with the fixed bit layout below.
package sfu_pkg;

    localparam int unsigned STATUS_W = 8;

    typedef enum logic [1:0] {
        OP_ADD  = 2'b00,
        OP_ADDC = 2'b01,
        OP_SUBB = 2'b10,
        OP_RSVD = 2'b11
    } alu_op_e;

    localparam logic [2:0] BIT_P     = 3'd0;
    localparam logic [2:0] BIT_SPARE = 3'd1;
    localparam logic [2:0] BIT_OV    = 3'd2;
    localparam logic [2:0] BIT_RS0   = 3'd3;
    localparam logic [2:0] BIT_RS1   = 3'd4;
    localparam logic [2:0] BIT_F0    = 3'd5;
    localparam logic [2:0] BIT_AC    = 3'd6;
    localparam logic [2:0] BIT_CY    = 3'd7;

    typedef struct packed {
        logic cy;
        logic ac;
        logic ov;
    } arith_flags_t;

endpackage

// File: rtl/sfu_addsub.sv
// Combinational adder/subtractor with flag extraction.
// The adder is split into three segments: low half, middle bits and
// the sign bit. This exposes the half carry and the carry into the
// sign bit directly. Subtraction adds the inverted operand and the
// inverted borrow, so a missing carry out means a borrow.
// Assumes DATA_W >= HALF_W + 2.
module sfu_addsub
    import sfu_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned HALF_W = 4
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    input  alu_op_e           op,
    output logic [DATA_W-1:0] sum,
    output arith_flags_t      flags
);
    localparam int unsigned MID_W = DATA_W - HALF_W;

    logic              is_sub;
    logic              c0;
    logic [DATA_W-1:0] b_eff;
    logic [HALF_W:0]   lo_seg;
    logic [MID_W-1:0]  mid_seg;
    logic [1:0]        top_seg;
    logic              c_into_sign;
    logic              c_out;

    // Select operand polarity and carry-in for the chosen operation
    always_comb begin
        is_sub = (op == OP_SUBB);
        b_eff  = is_sub ? ~b : b;
        unique case (op)
            OP_ADDC: c0 = cin;
            OP_SUBB: c0 = ~cin;
            default: c0 = 1'b0;
        endcase
    end

    // Three-segment ripple sum exposing internal carries
    always_comb begin
        lo_seg  = {1'b0, a[HALF_W-1:0]} + {1'b0, b_eff[HALF_W-1:0]}
                + {{HALF_W{1'b0}}, c0};
        mid_seg = {1'b0, a[DATA_W-2:HALF_W]} + {1'b0, b_eff[DATA_W-2:HALF_W]}
                + {{(MID_W-1){1'b0}}, lo_seg[HALF_W]};
        c_into_sign = mid_seg[MID_W-1];
        top_seg = {1'b0, a[DATA_W-1]} + {1'b0, b_eff[DATA_W-1]} + {1'b0, c_into_sign};
        c_out   = top_seg[1];
        sum     = {top_seg[0], mid_seg[MID_W-2:0], lo_seg[HALF_W-1:0]};
    end

    // Convert raw carries into flag meaning (borrow for subtract)
    always_comb begin
        flags.cy = is_sub ? ~c_out : c_out;
        flags.ac = is_sub ? ~lo_seg[HALF_W] : lo_seg[HALF_W];
        flags.ov = c_into_sign ^ c_out;
    end

endmodule

// File: rtl/sfu_parity.sv
// Odd-parity generator over the accumulator, built as an XOR chain.
// Output is 1 when the input holds an odd number of ones.
module sfu_parity #(
    parameter int unsigned DATA_W = 8
) (
    input  logic [DATA_W-1:0] data,
    output logic              odd
);
    logic [DATA_W:0] chain;

    assign chain[0] = 1'b0;
    for (genvar g = 0; g < DATA_W; g++) begin : g_xor
        assign chain[g+1] = chain[g] ^ data[g];
    end
    assign odd = chain[DATA_W];

endmodule

// File: rtl/sfu_status_reg.sv
// Status word register with fixed update priority.
// The lowest priority comes first; each later stage overrides the earlier ones:
// byte write, then bit write, then carry strobes, then arithmetic flags.
// Parity overwrites bit 0 on every edge. Synchronous active-low reset.
module sfu_status_reg
    import sfu_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                byte_we,
    input  logic [STATUS_W-1:0] byte_wdata,
    input  logic                bit_we,
    input  logic [2:0]          bit_idx,
    input  logic                bit_wval,
    input  logic                cy_set,
    input  logic                cy_clr,
    input  logic                arith_we,
    input  arith_flags_t        arith_flags,
    input  logic                parity_in,
    output logic [STATUS_W-1:0] status_q
);
    logic [STATUS_W-1:0] status_d;

    // Apply the update sources in ascending priority
    always_comb begin
        status_d = status_q;
        if (byte_we) status_d = byte_wdata;
        if (bit_we)  status_d[bit_idx] = bit_wval;
        if (cy_set)      status_d[BIT_CY] = 1'b1;
        else if (cy_clr) status_d[BIT_CY] = 1'b0;
        if (arith_we) begin
            status_d[BIT_CY] = arith_flags.cy;
            status_d[BIT_AC] = arith_flags.ac;
            status_d[BIT_OV] = arith_flags.ov;
        end
        status_d[BIT_P] = parity_in;
    end

    // Hold the status word
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= status_d;
    end

    // R5
    property parity_follow_p;
        @(posedge clk) disable iff (!rst_n) 1'b1 |=> (status_q[BIT_P] == $past(parity_in));
    endproperty
    parity_follow_chk: assert property (parity_follow_p);

    // R8
    property f0_kept_p;
        @(posedge clk) disable iff (!rst_n)
            (arith_we && !byte_we && !(bit_we && bit_idx == BIT_F0)) |=> $stable(status_q[BIT_F0]);
    endproperty
    f0_kept_chk: assert property (f0_kept_p);

    // R7
    property cy_set_p;
        @(posedge clk) disable iff (!rst_n) (cy_set && !arith_we) |=> status_q[BIT_CY];
    endproperty
    cy_set_chk: assert property (cy_set_p);

endmodule

// File: rtl/status_flag_unit.sv
// Top level of the status flag unit. Combines the adder/subtractor, the
// accumulator parity generator and the status register. The result is
// combinational; all status bits update one edge after their cause.
// Assumes the status word is 8 bits with the layout in sfu_pkg.
module status_flag_unit
    import sfu_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned HALF_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [1:0]        op_sel,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic              carry_in,
    input  logic [DATA_W-1:0] acc_in,
    input  logic              wr_byte_en,
    input  logic [7:0]        wr_data,
    input  logic              wr_bit_en,
    input  logic [2:0]        wr_bit_idx,
    input  logic              wr_bit_val,
    input  logic              cy_set,
    input  logic              cy_clr,
    output logic [DATA_W-1:0] result,
    output logic [7:0]        status,
    output logic [1:0]        bank_sel
);
    arith_flags_t        flags_w;
    logic                parity_w;
    logic [STATUS_W-1:0] status_w;

    sfu_addsub #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_addsub (
        .a     (opnd_a),
        .b     (opnd_b),
        .cin   (carry_in),
        .op    (alu_op_e'(op_sel)),
        .sum   (result),
        .flags (flags_w)
    );

    sfu_parity #(.DATA_W(DATA_W)) u_parity (
        .data (acc_in),
        .odd  (parity_w)
    );

    sfu_status_reg u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .byte_we     (wr_byte_en),
        .byte_wdata  (wr_data),
        .bit_we      (wr_bit_en),
        .bit_idx     (wr_bit_idx),
        .bit_wval    (wr_bit_val),
        .cy_set      (cy_set),
        .cy_clr      (cy_clr),
        .arith_we    (op_valid),
        .arith_flags (flags_w),
        .parity_in   (parity_w),
        .status_q    (status_w)
    );

    // Drive the status word and the bank-select field out
    always_comb begin
        status   = status_w;
        bank_sel = status_w[BIT_RS1:BIT_RS0];
    end

    // R4
    property plain_add_ov_p;
        @(posedge clk) disable iff (!rst_n)
            (op_valid && op_sel == 2'b00) |=>
            (status[BIT_OV] == (($past(opnd_a[DATA_W-1]) == $past(opnd_b[DATA_W-1])) &&
                                ($past(result[DATA_W-1]) != $past(opnd_a[DATA_W-1]))));
    endproperty
    no_overflow_chk: assert property (plain_add_ov_p);

    // R6
    property bank_after_reset_p;
        @(posedge clk) !rst_n |=> (bank_sel == 2'b00);
    endproperty
    bank_reset_chk: assert property (bank_after_reset_p);

endmodule

// File: tb/status_flag_unit_tb.sv
module status_flag_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       op_valid;
    logic [1:0] op_sel;
    logic [7:0] opnd_a, opnd_b, acc_in, wr_data;
    logic       carry_in, wr_byte_en, wr_bit_en, wr_bit_val, cy_set, cy_clr;
    logic [2:0] wr_bit_idx;
    logic [7:0] result, status;
    logic [1:0] bank_sel;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] m_st;

    always #4 clk = ~clk;

    status_flag_unit u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .carry_in(carry_in), .acc_in(acc_in),
        .wr_byte_en(wr_byte_en), .wr_data(wr_data), .wr_bit_en(wr_bit_en),
        .wr_bit_idx(wr_bit_idx), .wr_bit_val(wr_bit_val), .cy_set(cy_set),
        .cy_clr(cy_clr), .result(result), .status(status), .bank_sel(bank_sel)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // Reference arithmetic on integers
    task automatic ref_arith(input logic [1:0] op, input logic [7:0] a, input logic [7:0] b,
                             input logic c, output logic [7:0] r, output logic cy,
                             output logic ac, output logic ov);
        int ua = int'(a);
        int ub = int'(b);
        int sa = int'($signed(a));
        int sb = int'($signed(b));
        int ci = (op == 2'b01 || op == 2'b10) ? int'(c) : 0;
        int d, s;
        if (op == 2'b10) begin
            d = ua - ub - ci;
            cy = (d < 0);
            ac = ((ua % 16) - (ub % 16) - ci) < 0;
            s = sa - sb - ci;
        end else begin
            d = ua + ub + ci;
            cy = (d > 255);
            ac = ((ua % 16) + (ub % 16) + ci) > 15;
            s = sa + sb + ci;
        end
        r = 8'(d & 255);
        ov = (s < -128) || (s > 127);
    endtask

    function automatic logic odd_ones(input logic [7:0] v);
        int n = 0;
        for (int i = 0; i < 8; i++) if (v[i]) n++;
        return (n % 2) == 1;
    endfunction

    // Drive one cycle of stimulus, check result now and status after the edge
    task automatic step(input logic ov_en, input logic [1:0] op, input logic [7:0] a,
                        input logic [7:0] b, input logic c, input logic [7:0] acc,
                        input logic bwe, input logic [7:0] bwd, input logic bitwe,
                        input logic [2:0] idx, input logic bval, input logic cs,
                        input logic cc);
        logic [7:0] r, nx;
        logic cy, ac, ov;
        op_valid = ov_en; op_sel = op; opnd_a = a; opnd_b = b; carry_in = c;
        acc_in = acc; wr_byte_en = bwe; wr_data = bwd; wr_bit_en = bitwe;
        wr_bit_idx = idx; wr_bit_val = bval; cy_set = cs; cy_clr = cc;
        ref_arith(op, a, b, c, r, cy, ac, ov);
        #1;
        chk("R1 result", result, r);
        nx = m_st;
        if (bwe) nx = bwd;
        if (bitwe) nx[idx] = bval;
        if (cs) nx[7] = 1'b1;
        else if (cc) nx[7] = 1'b0;
        if (ov_en) begin nx[7] = cy; nx[6] = ac; nx[2] = ov; end
        nx[0] = odd_ones(acc);
        @(posedge clk);
        @(negedge clk);
        m_st = nx;
        chk("R2 carry", {7'd0, status[7]}, {7'd0, m_st[7]});
        chk("R3 aux carry", {7'd0, status[6]}, {7'd0, m_st[6]});
        chk("R4 overflow", {7'd0, status[2]}, {7'd0, m_st[2]});
        chk("R5 parity", {7'd0, status[0]}, {7'd0, m_st[0]});
        chk("R6 bank_sel", {6'd0, bank_sel}, {6'd0, m_st[4:3]});
        chk("R8 F0", {7'd0, status[5]}, {7'd0, m_st[5]});
        chk("R9 status word", status, m_st);
    endtask

    task automatic arith(input logic [1:0] op, input logic [7:0] a, input logic [7:0] b,
                         input logic c, input logic [7:0] acc);
        step(1'b1, op, a, b, c, acc, 1'b0, 8'h00, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog all-requirements actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; op_valid = 0; op_sel = 0; opnd_a = 0; opnd_b = 0; carry_in = 0;
        acc_in = 8'h01; wr_byte_en = 0; wr_data = 0; wr_bit_en = 0; wr_bit_idx = 0;
        wr_bit_val = 0; cy_set = 0; cy_clr = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R10 reset state, R6 bank 0
        chk("R10 reset status", status, 8'h00);
        chk("R6 reset bank", {6'd0, bank_sel}, 8'h00);
        m_st = 8'h00;
        rst_n = 1'b1;

        // Add boundaries: R2, R3, R4
        arith(2'b00, 8'h7F, 8'h01, 1'b0, 8'h80);
        arith(2'b00, 8'hFF, 8'h01, 1'b0, 8'h00);
        arith(2'b00, 8'h80, 8'h80, 1'b0, 8'h00);
        arith(2'b00, 8'h0F, 8'h00, 1'b1, 8'h07);
        arith(2'b11, 8'h12, 8'h34, 1'b1, 8'h46);
        // Add with carry
        arith(2'b01, 8'h0F, 8'h00, 1'b1, 8'h10);
        arith(2'b01, 8'hFF, 8'h00, 1'b1, 8'h00);
        // Subtract with borrow
        arith(2'b10, 8'h00, 8'h01, 1'b0, 8'hFF);
        arith(2'b10, 8'h80, 8'h01, 1'b0, 8'h7F);
        arith(2'b10, 8'h10, 8'h0F, 1'b1, 8'h00);
        arith(2'b10, 8'h7F, 8'hFF, 1'b0, 8'h80);
        arith(2'b10, 8'h05, 8'h05, 1'b1, 8'hFF);

        // R7 carry strobes, set wins, arithmetic overrides
        step(0, 2'b00, 0, 0, 0, 8'h03, 0, 0, 0, 0, 0, 1, 0);
        step(0, 2'b00, 0, 0, 0, 8'h03, 0, 0, 0, 0, 0, 0, 1);
        step(0, 2'b00, 0, 0, 0, 8'h03, 0, 0, 0, 0, 0, 1, 1);
        step(1, 2'b00, 8'h01, 8'h01, 0, 8'h03, 0, 0, 0, 0, 0, 1, 0);

        // R9 byte write, bit write precedence; R5 write to parity ignored
        step(0, 2'b00, 0, 0, 0, 8'h00, 1, 8'hFF, 0, 0, 0, 0, 0);
        step(0, 2'b00, 0, 0, 0, 8'h01, 1, 8'h00, 1, 3'd4, 1, 0, 0);
        step(0, 2'b00, 0, 0, 0, 8'h00, 0, 0, 1, 3'd0, 1, 0, 0);
        step(0, 2'b00, 0, 0, 0, 8'h00, 0, 0, 1, 3'd3, 1, 0, 0);
        // R8 F0 set, then arithmetic leaves it
        step(0, 2'b00, 0, 0, 0, 8'h00, 0, 0, 1, 3'd5, 1, 0, 0);
        arith(2'b00, 8'hFF, 8'hFF, 1'b0, 8'hFE);
        arith(2'b10, 8'h00, 8'hFF, 1'b1, 8'h00);

        // Randomised mix
        for (int k = 0; k < 400; k++) begin
            step(1'($urandom % 4 != 0), 2'($urandom), 8'($urandom), 8'($urandom),
                 1'($urandom), 8'($urandom), 1'($urandom % 8 == 0), 8'($urandom),
                 1'($urandom % 6 == 0), 3'($urandom), 1'($urandom),
                 1'($urandom % 7 == 0), 1'($urandom % 7 == 0));
        end

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule